// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is an up-counting interval timer advanced by a one-microsecond tick enable. Software programs a next-interval value, then starts the timer. The count register climbs by one per tick. When it rolls over from all-ones to zero it is reloaded from the next-interval register, so each interval lasts the two's complement of the programmed value. Every rollover raises a done flag. If done is still set from the previous rollover, an error flag is raised instead to record the missed interval. A level interrupt request follows done gated by interrupt-enable.

Control is a two-state machine. `ST_IDLE` is stopped and `ST_COUNT` is running. The transition `ST_IDLE -> ST_COUNT` fires on a control write with the run bit set. The transition `ST_COUNT -> ST_IDLE` fires on a control write with the run bit clear. While stopped the count is frozen, but software may still step it by one or load it from the next-interval register. A simple word-addressed write port and a combinational read port give access to the control/status, next-interval and count registers.

Top module: `ivtimer`

## Requirements
- R1: Reset clears the control/status word, the next-interval register, the count and the interrupt request.
- R2: In `ST_COUNT` the count rises by one on each cycle with `tick` high. In `ST_IDLE` ticks leave the count frozen.
- R3: On a rollover from all-ones the count takes the next-interval value, so an interval spans 2^WIDTH minus that value ticks (2^WIDTH ticks for a value of zero).
- R4: A rollover sets done (bit 7) when done is clear. If done is already set, the rollover sets error (bit 31) and done remains set.
- R5: Done and error clear when a control write has a one in their bit position. Run (bit 0) and interrupt-enable (bit 6) take the written value. Transfer (bit 4) and single-step (bit 5) always read as zero.
- R6: A control write with transfer set copies next-interval into the count. A tick in the same cycle is ignored, and counting resumes from the loaded value on the next tick.
- R7: A control write with run clear and single-step set advances the count by one, starting from the next-interval value if transfer is also set. A rollover caused by a step reloads the count and flags done or error exactly as a tick would.
- R8: `irq` is high exactly while done and interrupt-enable are both set. It changes on the same clock edge as those bits.
- R9: When a rollover and a control write that clears the same flag occur in one cycle, the flag ends up set.
- R10: Word address 0 is control/status, 1 is next-interval (read/write, low WIDTH bits kept) and 2 is the count (read-only; writes are ignored). Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count enable at the timer rate |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sweeps every next-interval value of an 8-bit count and measures the ticks to the first interrupt. A reload taken from the wrong register, or an off-by-one rollover test, would give an interval one tick off or a wrong residual count. It lets two rollovers pass unacknowledged to make error appear. A design that set done twice, or cleared done on overrun, would show the wrong status word. It also tests the cases where events meet in one cycle: a transfer together with a tick must not advance the count, a step together with a transfer must count from the loaded value, and a rollover together with a clear of done must leave done set. Reads of the count after ticks with run clear expose a timer that fails to freeze.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W   = 32;
    localparam int BIT_RUN  = 0;
    localparam int BIT_XFR  = 4;
    localparam int BIT_SGL  = 5;
    localparam int BIT_IE   = 6;
    localparam int BIT_DONE = 7;
    localparam int BIT_ERR  = 31;

    localparam logic [1:0] ADDR_CSR  = 2'd0;
    localparam logic [1:0] ADDR_NEXT = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;
endpackage

// File: rtl/ivt_count.sv
module ivt_count #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [WIDTH-1:0] reload,
    output logic [WIDTH-1:0] count_q,
    output logic             wrap
);
    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] count_d;

    always_comb begin
        base = load ? reload : count_q;
        wrap = adv && (base == {WIDTH{1'b1}});
        if (wrap)
            count_d = reload;
        else if (adv)
            count_d = base + 1'b1;
        else
            count_d = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end
endmodule

// File: rtl/ivt_flags.sv
module ivt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic csr_wr,
    input  logic ie_wr,
    input  logic clr_done,
    input  logic clr_err,
    input  logic wrap,
    output logic done_q,
    output logic err_q,
    output logic ie_q,
    output logic irq_q
);
    logic done_d;
    logic err_d;
    logic ie_d;

    always_comb begin
        // a rollover's set beats a same-cycle software clear
        done_d = (done_q & ~(csr_wr & clr_done)) | (wrap & ~done_q);
        err_d  = (err_q  & ~(csr_wr & clr_err))  | (wrap &  done_q);
        ie_d   = csr_wr ? ie_wr : ie_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            ie_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            done_q <= done_d;
            err_q  <= err_d;
            ie_q   <= ie_d;
            irq_q  <= done_d & ie_d;
        end
    end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int PAD_W = DATA_W - WIDTH;

    run_state_e       state_q;
    run_state_e       state_d;
    logic             running;
    logic             csr_wr;
    logic             next_wr;
    logic             xfr;
    logic             step;
    logic             adv;
    logic             wrap;
    logic [WIDTH-1:0] nicr_q;
    logic [WIDTH-1:0] count_q;
    logic             done_q;
    logic             err_q;
    logic             ie_q;
    logic [DATA_W-1:0] csr_view;

    assign csr_wr  = reg_wr && (reg_addr == ADDR_CSR);
    assign next_wr = reg_wr && (reg_addr == ADDR_NEXT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (csr_wr &&  reg_wdata[BIT_RUN]) state_d = ST_COUNT;
            ST_COUNT: if (csr_wr && !reg_wdata[BIT_RUN]) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        running = (state_q == ST_COUNT);
        xfr     = csr_wr && reg_wdata[BIT_XFR];
        step    = csr_wr && !reg_wdata[BIT_RUN] && reg_wdata[BIT_SGL];
        adv     = step || (running && tick && !xfr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nicr_q <= '0;
        else if (next_wr)
            nicr_q <= reg_wdata[WIDTH-1:0];
    end

    ivt_count #(.WIDTH(WIDTH)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (xfr),
        .adv     (adv),
        .reload  (nicr_q),
        .count_q (count_q),
        .wrap    (wrap)
    );

    ivt_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (csr_wr),
        .ie_wr    (reg_wdata[BIT_IE]),
        .clr_done (reg_wdata[BIT_DONE]),
        .clr_err  (reg_wdata[BIT_ERR]),
        .wrap     (wrap),
        .done_q   (done_q),
        .err_q    (err_q),
        .ie_q     (ie_q),
        .irq_q    (irq)
    );

    always_comb begin
        csr_view           = '0;
        csr_view[BIT_RUN]  = running;
        csr_view[BIT_IE]   = ie_q;
        csr_view[BIT_DONE] = done_q;
        csr_view[BIT_ERR]  = err_q;
        unique case (reg_addr)
            ADDR_CSR:  reg_rdata = csr_view;
            ADDR_NEXT: reg_rdata = {{PAD_W{1'b0}}, nicr_q};
            ADDR_CNT:  reg_rdata = {{PAD_W{1'b0}}, count_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             running,
    input logic [WIDTH-1:0] count_q,
    input logic [WIDTH-1:0] nicr_q,
    input logic             done_q,
    input logic             err_q,
    input logic             ie_q,
    input logic             irq
);
    logic csr_hit;
    assign csr_hit = reg_wr && (reg_addr == 2'd0);

    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (done_q && ie_q));

    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !csr_hit) |=> (count_q == $past(count_q)));

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !csr_hit && count_q != {WIDTH{1'b1}})
        |=> (count_q == WIDTH'($past(count_q) + 1'b1)));

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !csr_hit && count_q == {WIDTH{1'b1}})
        |=> (count_q == $past(nicr_q) && done_q));

    a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !reg_wr && done_q && count_q == {WIDTH{1'b1}})
        |=> (err_q && done_q));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && csr_hit && !reg_wdata[4] && !done_q && count_q == {WIDTH{1'b1}})
        |=> done_q);
endmodule

bind ivtimer ivt_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .running   (running),
    .count_q   (count_q),
    .nicr_q    (nicr_q),
    .done_q    (done_q),
    .err_q     (err_q),
    .ie_q      (ie_q),
    .irq       (irq)
);

// File: tb/ivtimer_bench.sv
module ivtimer_bench;
    localparam int W = 8;
    localparam logic [31:0] RUN  = 32'h1;
    localparam logic [31:0] XFR  = 32'h10;
    localparam logic [31:0] SGL  = 32'h20;
    localparam logic [31:0] IE   = 32'h40;
    localparam logic [31:0] DONE = 32'h80;
    localparam logic [31:0] ERR  = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] d;

    ivtimer #(.WIDTH(W)) u_ivtimer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, d); check("R1 csr", d, 0);
        rd(1, d); check("R1 next", d, 0);
        rd(2, d); check("R1 count", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R3 / R8 sweep over every next-interval value
        for (int v = 0; v < 256; v++) begin
            int n;
            wr(1, v);
            wr(0, RUN | XFR | IE | DONE | ERR);
            tick = 1'b1;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!irq && n < 300);
            tick = 1'b0;
            check("R3 interval", n, 256 - v);
            rd(2, d); check("R3 reload", d, v);
            wr(0, DONE);
        end

        // R4 / R5 / R8 overrun into error
        wr(1, 32'hFE);
        wr(0, RUN | XFR);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        rd(0, d); check("R4 done+err", d, RUN | DONE | ERR);
        check("R8 irq masked", {31'b0, irq}, 0);
        wr(0, RUN | IE);
        rd(0, d); check("R5 ie rw", d, RUN | IE | DONE | ERR);
        check("R8 irq on", {31'b0, irq}, 1);
        wr(0, RUN | IE | DONE);
        rd(0, d); check("R5 w1c done", d, RUN | IE | ERR);
        check("R8 irq off", {31'b0, irq}, 0);
        wr(0, IE | ERR);
        rd(0, d); check("R5 w1c err", d, IE);

        // R2 frozen while stopped
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        rd(2, d); check("R2 frozen", d, 32'hFE);
        wr(0, RUN);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        rd(2, d); check("R2 advance", d, 32'hFF);
        wr(0, 0);

        // R7 single step
        wr(1, 32'hFD);
        wr(0, XFR | SGL | IE);
        rd(2, d); check("R7 xfr+step", d, 32'hFE);
        rd(0, d); check("R5 xfr sgl read zero", d, IE);
        wr(0, SGL | IE);
        rd(2, d); check("R7 step", d, 32'hFF);
        check("R7 no irq yet", {31'b0, irq}, 0);
        wr(0, SGL | IE);
        rd(2, d); check("R7 step reload", d, 32'hFD);
        rd(0, d); check("R7 step done", d, IE | DONE);
        check("R7 step irq", {31'b0, irq}, 1);
        wr(0, DONE);

        // R9 rollover beats clear
        wr(1, 32'hFF);
        wr(0, XFR);
        wr(0, RUN);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 0; reg_wdata = RUN | DONE; tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick = 1'b0;
        rd(0, d); check("R9 set wins", d, RUN | DONE);
        rd(2, d); check("R9 count", d, 32'hFF);
        wr(0, RUN | DONE);
        rd(0, d); check("R9 later clear", d, RUN);

        // R6 transfer with tick restarts
        wr(1, 32'h10);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 0; reg_wdata = RUN | XFR; tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        tick = 1'b0;
        rd(2, d); check("R6 restart", d, 32'h11);
        wr(0, 0);

        // R10 register map
        wr(2, 32'h55);
        rd(2, d); check("R10 count ro", d, 32'h11);
        rd(3, d); check("R10 addr3", d, 0);
        wr(1, 32'h1234);
        rd(1, d); check("R10 next width", d, 32'h34);

        // R1 reset mid-run
        wr(0, RUN | IE);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        tick = 1'b0;
        rst_n = 1'b1;
        rd(0, d); check("R1 csr after reset", d, 0);
        rd(1, d); check("R1 next after reset", d, 0);
        rd(2, d); check("R1 count after reset", d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule